// File: doc/BRIEF.md
# First-Bit Pulse-Length Header Receiver

This block sits on one input of a small packet switch and watches an oversampled serial light line, with `TICK_PER_BIT` clock ticks per bit period. It finds where a packet begins and ends from the presence of light alone. The end of a packet is a long dark run; no length field is read. It also recovers the first routing bit of the packet without a recovered clock. The first light pulse carries that bit in its length: a pulse of two bit periods means 0 and a pulse of one bit period means 1. The receiver decides which by looking at a copy of the line delayed by 1.3 bit periods at the moment the first pulse goes dark.

The decoded bit is held in a routing latch for the downstream arbiter. Two flags rise together inside the first gap, 2.5 bit periods after the start: `valid_o` tells the arbiter that the latch can be used, and `mask_o` lets the switch fabric suppress the first pulse on the forwarded copy. Both flags and the latch clear when the packet ends. All delays are rounded to whole ticks. With the default of 10 ticks per bit, the edge window is 5 ticks, the sample delay 13, the flag delay 25 and the end-of-packet dark run 60.

The block has no data stream with back-pressure. Every pin is a plain control or status level or pulse, and the line input is taken on every tick.

Top module: `pulse_hdr_rx`

## Requirements
- R1: After reset, and while the line stays dark, `start_o`, `end_o`, `busy_o`, `route_o`, `valid_o` and `mask_o` are all 0.
- R2: When idle, `start_o` is high for exactly one cycle: the cycle after the clock edge that first samples `line_i` high.
- R3: `end_o` is high for exactly one cycle: the cycle after the 6T-th consecutive low sample that follows the last high sample. A dark run of 6T-1 samples inside a packet produces no end.
- R4: Within a packet, from the start up to and including the end pulse, `start_o` stays low, whatever light pattern arrives.
- R5: `route_o` takes the value of the first pulse one cycle after the first low sample that follows it. If the first pulse lasted at least round(1.3T) samples (13 by default), `route_o` is 0; if it was shorter, `route_o` is 1.
- R6: The decode tolerates pulse-length error. A nominal 2T pulse decodes as 0 when shortened or lengthened by up to 0.42T (16 to 24 samples by default). A nominal 1T pulse decodes as 1 from 0.6T to 1.2T (6 to 12 samples).
- R7: `valid_o` and `mask_o` rise together round(2.5T) cycles after the `start_o` cycle (25 by default) and are low in the cycle before.
- R8: While `valid_o` is high, `route_o` holds its value, whatever later pulses arrive. In the cycle after `end_o`, `route_o`, `valid_o` and `mask_o` are 0.
- R9: If the first pulse has not gone dark by the time `valid_o` rises, `route_o` stays 0 for that packet.
- R10: `busy_o` is high from the cycle after `start_o` through the `end_o` cycle, and low in the cycle after `end_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, `TICK_PER_BIT` ticks per bit period |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Oversampled line, 1 = light present |
| start_o | output | 1 | One-cycle packet start pulse |
| end_o | output | 1 | One-cycle packet end pulse |
| busy_o | output | 1 | A packet is in flight |
| route_o | output | 1 | Decoded first routing bit |
| valid_o | output | 1 | Routing bit may be used by the arbiter |
| mask_o | output | 1 | First-pulse suppression enable for the fabric |

## Verification
The flag timer that raises `valid_o` and the decoder that captures the first falling edge can act in the same cycle. A first pulse of 24 samples goes dark in the last cycle before the flags rise, and a pulse of 25 samples goes dark in the cycle they rise. The bench sweeps the first-pulse length from 1 to 30 samples, so both lengths are covered. For every length it checks the flag rise cycle, the routing value it computes from the pulse length, and that the latch does not change after `valid_o` is high.

// File: rtl/phr_pkg.sv
package phr_pkg;
  // Convert a delay in tenths of a bit period to whole ticks, rounded.
  function automatic int tenths_to_ticks(input int ticks_per_bit, input int tenths);
    return (tenths * ticks_per_bit + 5) / 10;
  endfunction
endpackage

// File: rtl/phr_tap_delay.sv
module phr_tap_delay #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
    end else if (DEPTH == 1) begin : g_one
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_chain
      logic [DEPTH-1:0] sh_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_r <= '0;
        else        sh_r <= {sh_r[DEPTH-2:0], d_i};
      end
      assign q_o = sh_r[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/phr_activity.sv
module phr_activity #(
  parameter int DARK_TICKS = 60,
  parameter int EDGE_DLY   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_q_i,
  output logic start_o,
  output logic end_o,
  output logic busy_o
);
  localparam int DW = $clog2(DARK_TICKS);
  localparam logic [DW-1:0] DARK_MAX = DW'(DARK_TICKS - 1);

  logic [DW-1:0] dark_run_q;
  logic          act;
  logic          act_dly;
  logic          busy_q;

  // Count dark samples since the last light, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dark_run_q <= DARK_MAX;
    else if (line_q_i)          dark_run_q <= '0;
    else if (dark_run_q != DARK_MAX) dark_run_q <= dark_run_q + 1'b1;
  end

  assign act = line_q_i | (dark_run_q < DARK_MAX);

  phr_tap_delay #(.DEPTH(EDGE_DLY)) u_act_dly (
    .clk(clk), .rst_n(rst_n), .d_i(act), .q_o(act_dly)
  );

  assign start_o = act & ~act_dly & ~busy_q;
  assign end_o   = ~act & act_dly & busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (start_o) busy_q <= 1'b1;
    else if (end_o)   busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  assert_end_on_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> !line_q_i);
  assert_busy_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_o);
  assert_idle_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !busy_o);
endmodule

// File: rtl/phr_bit_decode.sv
module phr_bit_decode #(
  parameter int SAMPLE_DLY = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_q_i,
  input  logic start_i,
  input  logic end_i,
  input  logic valid_i,
  output logic route_o
);
  logic line_prev_q;
  logic tap;
  logic wait_q;
  logic route_q;
  logic first_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_prev_q <= 1'b0;
    else        line_prev_q <= line_q_i;
  end

  phr_tap_delay #(.DEPTH(SAMPLE_DLY)) u_sample_dly (
    .clk(clk), .rst_n(rst_n), .d_i(line_q_i), .q_o(tap)
  );

  assign first_fall = wait_q & line_prev_q & ~line_q_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wait_q <= 1'b0;
    else if (start_i)                wait_q <= 1'b1;
    else if (first_fall || end_i)    wait_q <= 1'b0;
  end

  // Light still present in the delayed copy means a long (0) pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        route_q <= 1'b0;
    else if (end_i)                    route_q <= 1'b0;
    else if (first_fall && !valid_i)   route_q <= ~tap;
  end

  assign route_o = route_q;

  assert_route_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !end_i) |=> $stable(route_q));
  assert_route_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_i |=> !route_q);
endmodule

// File: rtl/phr_flag_timer.sv
module phr_flag_timer #(
  parameter int VALID_DLY = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic end_i,
  input  logic busy_i,
  output logic valid_o,
  output logic mask_o
);
  localparam int CW = $clog2(VALID_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(VALID_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          valid_q;
  logic          mask_q;
  logic          fire;

  assign fire = (cnt_q == LAST) && !valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (start_i)                cnt_q <= CW'(1);
    else if (end_i || fire)          cnt_q <= '0;
    else if (cnt_q != '0)            cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= 1'b0;
    end else if (end_i) begin
      valid_q <= 1'b0;
      mask_q  <= 1'b0;
    end else if (fire) begin
      valid_q <= 1'b1;
      mask_q  <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign mask_o  = mask_q;

  assert_no_early_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !valid_q);
  assert_valid_in_pkt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> busy_i);
endmodule

// File: rtl/pulse_hdr_rx.sv
module pulse_hdr_rx #(
  parameter int TICK_PER_BIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic start_o,
  output logic end_o,
  output logic busy_o,
  output logic route_o,
  output logic valid_o,
  output logic mask_o
);
  import phr_pkg::*;

  localparam int EDGE_DLY   = tenths_to_ticks(TICK_PER_BIT, 5);
  localparam int SAMPLE_DLY = tenths_to_ticks(TICK_PER_BIT, 13);
  localparam int VALID_DLY  = tenths_to_ticks(TICK_PER_BIT, 25);
  localparam int DARK_TICKS = 6 * TICK_PER_BIT;

  logic line_q;
  logic start_w, end_w, busy_w, valid_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_i;
  end

  phr_activity #(.DARK_TICKS(DARK_TICKS), .EDGE_DLY(EDGE_DLY)) u_act (
    .clk(clk), .rst_n(rst_n), .line_q_i(line_q),
    .start_o(start_w), .end_o(end_w), .busy_o(busy_w)
  );

  phr_flag_timer #(.VALID_DLY(VALID_DLY)) u_flags (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .end_i(end_w),
    .busy_i(busy_w), .valid_o(valid_w), .mask_o(mask_o)
  );

  phr_bit_decode #(.SAMPLE_DLY(SAMPLE_DLY)) u_dec (
    .clk(clk), .rst_n(rst_n), .line_q_i(line_q), .start_i(start_w),
    .end_i(end_w), .valid_i(valid_w), .route_o(route_o)
  );

  assign start_o = start_w;
  assign end_o   = end_w;
  assign busy_o  = busy_w;
  assign valid_o = valid_w;

  assert_start_end_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_w && end_w));
endmodule

// File: tb/sim_pulse_hdr_rx.sv
module sim_pulse_hdr_rx;
  localparam int T      = 10;
  localparam int SAMPLE = (13 * T + 5) / 10;
  localparam int VLD    = (25 * T + 5) / 10;
  localparam int DARK   = 6 * T;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_i = 1'b0;
  logic start_o, end_o, busy_o, route_o, valid_o, mask_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pulse_hdr_rx #(.TICK_PER_BIT(T)) u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .start_o(start_o), .end_o(end_o),
    .busy_o(busy_o), .route_o(route_o), .valid_o(valid_o), .mask_o(mask_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic v);
    line_i = v;
    @(posedge clk);
    #1;
  endtask

  function automatic logic pat(input int L, input int n);
    if (n < L) return 1'b1;
    if (n < L + 8) return 1'b0;
    if (n < L + 18) return 1'b1;
    if (n < L + 58) return (((n - L - 18) / 5) % 2 == 0);
    return 1'b0;
  endfunction

  task automatic run_packet(input int L);
    int exp_bit = (L >= SAMPLE || L >= VLD) ? 0 : 1;
    int last_h  = L + 52;
    int e       = last_h + DARK;
    int bad_start = 0;
    string rq;
    if (L >= VLD) rq = "R9";
    else if ((L >= 6 && L <= 12) || (L >= 16 && L <= 24)) rq = "R6";
    else rq = "R5";
    for (int n = 0; n <= e + 1; n++) begin
      tick(pat(L, n));
      if (n == 0) chk("R2 start pulse", start_o, 1);
      if (n >= 1 && n <= e && start_o) bad_start++;
      if (n == 1) chk("R10 busy after start", busy_o, 1);
      if (n == VLD - 1) chk("R7 valid early", valid_o, 0);
      if (n == VLD) chk("R7 valid+mask rise", {31'd0, valid_o & mask_o}, 1);
      if (L < VLD && n == L + 1) chk({rq, " route after fall"}, route_o, exp_bit);
      if (n == VLD + 1) chk({rq, " route at valid"}, route_o, exp_bit);
      if (n == e - 1) chk("R3 no early end", end_o, 0);
      if (n == e) begin
        chk("R3 end pulse", end_o, 1);
        chk("R8 route held to end", route_o, exp_bit);
      end
      if (n == e + 1) begin
        chk("R8 cleared after end", {29'd0, route_o, valid_o, mask_o}, 0);
        chk("R10 busy low after end", busy_o, 0);
      end
    end
    chk("R4 no restart in packet", bad_start, 0);
    for (int i = 0; i < 10; i++) tick(1'b0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 8; i++) tick(1'b0);
    chk("R1 reset state", {26'd0, start_o, end_o, busy_o, route_o, valid_o, mask_o}, 0);

    // Sweep the first-pulse length, including the flag/fall collision at 24 and 25.
    for (int L = 1; L <= 30; L++) run_packet(L);

    // A dark run one sample short of the end limit keeps the packet alive.
    begin
      int bad = 0;
      int e = 78 + DARK;
      for (int n = 0; n <= e + 1; n++) begin
        tick((n < 10) || (n >= 69 && n < 79));
        if (n >= 1 && n < e && (start_o || end_o)) bad++;
        if (n == 100) chk("R8 route kept over gap", route_o, 1);
        if (n == e) chk("R3 end after long gap", end_o, 1);
      end
      chk("R3 R4 no end or restart on 6T-1 gap", bad, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule